// File: doc/BRIEF.md
# Key-Locked GPIO Bank Controller

This block controls a bank of general-purpose pins through a small 32-bit register port. Every pin has two mode bits and one output data bit. Together they select one of four drive behaviours: high-impedance input, push-pull output, a mode that can only pull the pad low, and a mode that can only pull it high. The output data bits change only through write-one-to-set and write-one-to-clear registers, so software can change single pins without a read-modify-write. The block samples the pad inputs through a synchronizer, and they can be read back.

The drive configuration is protected. Writes to either mode register, and to their set and clear aliases, take effect only while a lock register on a separate small port is active. The lock becomes active only when a fixed 16-bit key is written into the low half of that register. Writing zero releases it. Boot code opens the lock, changes directions, closes it again, and can restore a saved configuration with whole-register mode writes.

Top module: `keyed_gpio_bank`

## Requirements
- R1: After reset, both mode registers and all output data bits are zero, every `pad_oe` bit is 0, and `lk_rdata` reads 0.
- R2: A lock write with `lk_wdata[15:0]` = 0xD42F makes the lock active. A lock write with 0x0000 there makes it inactive. Any other value leaves the lock state unchanged. `lk_rdata` shows the lock state in bit 31 and 0 in all other bits, and the state changes on the clock edge that takes the write.
- R3: While the lock is inactive, writes to mode1 (0x08), mode0 (0x0C), mode1-clear (0x50), mode0-set (0x54) and mode0-clear (0x58) leave both mode registers unchanged.
- R4: While the lock is active, a write to 0x08 or 0x0C replaces the whole mode1 or mode0 register. Reads at those offsets return the register contents.
- R5: While the lock is active, a write to 0x50 clears the mode1 bits written as 1. A write to 0x54 sets the mode0 bits written as 1, and a write to 0x58 clears the mode0 bits written as 1. Bits written as 0 are unchanged.
- R6: A write to 0x14 sets, and a write to 0x18 clears, each output data bit written as 1. Bits written as 0 are unchanged. These writes do not depend on the lock.
- R7: A pin with {mode1,mode0} = 00 has `pad_oe` = 0 and `pad_out` = 0, whatever its data bit holds.
- R8: A pin with {mode1,mode0} = 01 has `pad_oe` = 1 and `pad_out` equal to its data bit.
- R9: A pin with {mode1,mode0} = 10 has `pad_out` = 0 and `pad_oe` equal to the inverse of its data bit: it drives low for data 0 and floats for data 1.
- R10: A pin with {mode1,mode0} = 11 has `pad_out` = 1 and `pad_oe` equal to its data bit: it floats for data 0 and drives high for data 1.
- R11: A read at 0x04 returns `pad_in` through a two-flop synchronizer. A pad value held across two clock edges is visible, and after only one edge the previous value still shows.
- R12: Write-data bits at or above NPINS have no effect, and those bit positions read as 0 at every offset.
- R13: A read at any offset other than 0x04, 0x08 or 0x0C returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register port write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Register byte offset, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| lk_wr_en | input | 1 | Lock port write strobe |
| lk_wdata | input | 32 | Lock write data; only bits 15:0 are decoded |
| lk_rdata | output | 32 | Lock status, active state in bit 31 |
| pad_in | input | NPINS | Pad input levels, asynchronous |
| pad_oe | output | NPINS | Per-pin output enable |
| pad_out | output | NPINS | Per-pin output value |

## Verification
The assertions take for granted that the write strobes and the address are known values whenever reset is deasserted. They also assume a single write on the register port in a given cycle touches only one offset. This means the set and clear aliases never meet in the same cycle. The stimulus holds every input at defined values from time zero and changes them only on the falling clock edge. It issues at most one register write and one lock write per transaction. Random lock values are mixed with the key and with zero so that the hold case of the lock is also exercised.

// File: rtl/gpk_pkg.sv
package gpk_pkg;
   localparam int REG_W = 32;
   localparam int MAX_PINS = 32;
   localparam logic [15:0] LOCK_KEY = 16'hD42F;

   // register byte offsets (what software decodes)
   localparam logic [7:0] OFS_M0_SET = 8'h54;
   localparam logic [7:0] OFS_DOUT_CLR = 8'h18;
   localparam logic [7:0] OFS_MODE1 = 8'h08;
   localparam logic [7:0] OFS_PADS = 8'h04;
   localparam logic [7:0] OFS_M1_CLR = 8'h50;
   localparam logic [7:0] OFS_MODE0 = 8'h0C;
   localparam logic [7:0] OFS_M0_CLR = 8'h58;
   localparam logic [7:0] OFS_DOUT_SET = 8'h14;

   typedef enum logic [1:0] {
      DM_INPUT     = 2'b00,
      DM_PUSHPULL  = 2'b01,
      DM_LOW_ONLY  = 2'b10,
      DM_HIGH_ONLY = 2'b11
   } drive_mode_e;
endpackage

// File: rtl/gpk_lock.sv
module gpk_lock
   import gpk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic             active
);
   logic key_hit;
   logic rel_hit;

   assign key_hit = (wdata[15:0] == LOCK_KEY);
   assign rel_hit = (wdata[15:0] == 16'h0000);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
      end else if (wr_en) begin
         if (key_hit)      active <= 1'b1;
         else if (rel_hit) active <= 1'b0;
      end
   end
endmodule

// File: rtl/gpk_sync.sv
module gpk_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpk_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpk_regs.sv
module gpk_regs
   import gpk_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NPINS-1:0]  wdata,
   input  logic              lock_on,
   output logic [NPINS-1:0]  mode0,
   output logic [NPINS-1:0]  mode1,
   output logic [NPINS-1:0]  dout
);
   logic hit_m0, hit_m1, hit_m0set, hit_m0clr, hit_m1clr;
   logic hit_dset, hit_dclr;
   logic mode_we;

   assign hit_m0    = (addr == ADDR_W'(OFS_MODE0));
   assign hit_m1    = (addr == ADDR_W'(OFS_MODE1));
   assign hit_m0set = (addr == ADDR_W'(OFS_M0_SET));
   assign hit_m0clr = (addr == ADDR_W'(OFS_M0_CLR));
   assign hit_m1clr = (addr == ADDR_W'(OFS_M1_CLR));
   assign hit_dset  = (addr == ADDR_W'(OFS_DOUT_SET));
   assign hit_dclr  = (addr == ADDR_W'(OFS_DOUT_CLR));
   assign mode_we   = wr_en && lock_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode0 <= '0;
      end else if (mode_we) begin
         if (hit_m0)         mode0 <= wdata;
         else if (hit_m0set) mode0 <= mode0 | wdata;
         else if (hit_m0clr) mode0 <= mode0 & ~wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode1 <= '0;
      end else if (mode_we) begin
         if (hit_m1)         mode1 <= wdata;
         else if (hit_m1clr) mode1 <= mode1 & ~wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
      end else if (wr_en) begin
         if (hit_dset)      dout <= dout | wdata;
         else if (hit_dclr) dout <= dout & ~wdata;
      end
   end
endmodule

// File: rtl/gpk_drive.sv
module gpk_drive
   import gpk_pkg::*;
#(
   parameter int NPINS = 32
) (
   input  logic [NPINS-1:0] mode0,
   input  logic [NPINS-1:0] mode1,
   input  logic [NPINS-1:0] dout,
   output logic [NPINS-1:0] oe,
   output logic [NPINS-1:0] val
);
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      drive_mode_e mode;
      assign mode = drive_mode_e'({mode1[i], mode0[i]});
      always_comb begin
         case (mode)
            DM_PUSHPULL:  begin oe[i] = 1'b1;     val[i] = dout[i]; end
            DM_LOW_ONLY:  begin oe[i] = ~dout[i]; val[i] = 1'b0;    end
            DM_HIGH_ONLY: begin oe[i] = dout[i];  val[i] = 1'b1;    end
            default:      begin oe[i] = 1'b0;     val[i] = 1'b0;    end
         endcase
      end
   end
endmodule

// File: rtl/keyed_gpio_bank.sv
module keyed_gpio_bank
   import gpk_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              lk_wr_en,
   input  logic [31:0]       lk_wdata,
   output logic [31:0]       lk_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_out
);
   localparam int PAD_BITS = REG_W - NPINS;

   if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_npins
      $error("keyed_gpio_bank: NPINS out of range");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("keyed_gpio_bank: ADDR_W too small for register map");
   end

   logic             lock_q;
   logic [NPINS-1:0] mode0_q, mode1_q, dout_q, pads_sync;
   logic [NPINS-1:0] rd_bits;

   gpk_lock u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (lk_wr_en),
      .wdata  (lk_wdata),
      .active (lock_q)
   );

   gpk_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .addr    (reg_addr),
      .wdata   (reg_wdata[NPINS-1:0]),
      .lock_on (lock_q),
      .mode0   (mode0_q),
      .mode1   (mode1_q),
      .dout    (dout_q)
   );

   gpk_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (pads_sync)
   );

   gpk_drive #(.NPINS(NPINS)) u_drive (
      .mode0 (mode0_q),
      .mode1 (mode1_q),
      .dout  (dout_q),
      .oe    (pad_oe),
      .val   (pad_out)
   );

   always_comb begin
      if (reg_addr == ADDR_W'(OFS_PADS))       rd_bits = pads_sync;
      else if (reg_addr == ADDR_W'(OFS_MODE1)) rd_bits = mode1_q;
      else if (reg_addr == ADDR_W'(OFS_MODE0)) rd_bits = mode0_q;
      else                                     rd_bits = '0;
   end

   if (PAD_BITS > 0) begin : g_zext
      assign reg_rdata = {{PAD_BITS{1'b0}}, rd_bits};
   end else begin : g_full
      assign reg_rdata = rd_bits;
   end

   assign lk_rdata = {lock_q, 31'b0};
endmodule

// File: rtl/gpk_checker.sv
module gpk_checker
   import gpk_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              lk_wr_en,
   input logic [31:0]       lk_wdata,
   input logic [31:0]       lk_rdata,
   input logic [NPINS-1:0]  mode0,
   input logic [NPINS-1:0]  mode1,
   input logic [NPINS-1:0]  dout,
   input logic [NPINS-1:0]  pad_oe,
   input logic [NPINS-1:0]  pad_out
);
   logic key_wr, rel_wr;
   assign key_wr = lk_wr_en && (lk_wdata[15:0] == LOCK_KEY);
   assign rel_wr = lk_wr_en && (lk_wdata[15:0] == 16'h0000);

   AST_LOCK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr |=> lk_rdata[31]); // R2
   AST_LOCK_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      rel_wr |=> !lk_rdata[31]); // R2
   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(key_wr || rel_wr) |=> $stable(lk_rdata)); // R2
   AST_MODE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_rdata[31] |=> ($stable(mode0) && $stable(mode1))); // R3
   AST_DOUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == ADDR_W'(OFS_DOUT_SET))
         |=> (($past(reg_wdata[NPINS-1:0]) & ~dout) == '0)); // R6
   AST_DOUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == ADDR_W'(OFS_DOUT_CLR))
         |=> (($past(reg_wdata[NPINS-1:0]) & dout) == '0)); // R6
   AST_INPUT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~(mode0 | mode1)) == '0); // R7
   AST_PUSHPULL: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode0 & ~mode1) & (~pad_oe | (pad_out ^ dout))) == '0); // R8
   AST_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode1 & ~mode0) & (pad_out | (pad_oe & dout))) == '0); // R9
   AST_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode1 & mode0) & (~pad_out | (pad_oe ^ dout))) == '0); // R10
endmodule

bind keyed_gpio_bank gpk_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr_en (reg_wr_en),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .lk_wr_en  (lk_wr_en),
   .lk_wdata  (lk_wdata),
   .lk_rdata  (lk_rdata),
   .mode0     (mode0_q),
   .mode1     (mode1_q),
   .dout      (dout_q),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out)
);

// File: tb/keyed_gpio_bank_tb.sv
module keyed_gpio_bank_tb;
   localparam int NP = 20;
   localparam int AW = 8;
   localparam logic [31:0] MASK = (32'd1 << NP) - 32'd1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr_en = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic lk_wr_en = 1'b0;
   logic [31:0] lk_wdata = '0;
   logic [31:0] lk_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_oe, pad_out;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // bench model
   logic [31:0] m0 = '0, m1 = '0, dd = '0;
   bit lk = 0;

   always #5 clk = ~clk;

   keyed_gpio_bank #(.NPINS(NP), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .lk_wr_en(lk_wr_en), .lk_wdata(lk_wdata), .lk_rdata(lk_rdata),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_oe(input logic [31:0] a1, a0, d);
      logic [31:0] r;
      for (int i = 0; i < 32; i++)
         case ({a1[i], a0[i]})
            2'b01:   r[i] = 1'b1;
            2'b10:   r[i] = ~d[i];
            2'b11:   r[i] = d[i];
            default: r[i] = 1'b0;
         endcase
      return r & MASK;
   endfunction

   function automatic logic [31:0] exp_out(input logic [31:0] a1, a0, d);
      logic [31:0] r;
      for (int i = 0; i < 32; i++)
         case ({a1[i], a0[i]})
            2'b01:   r[i] = d[i];
            2'b11:   r[i] = 1'b1;
            default: r[i] = 1'b0;
         endcase
      return r & MASK;
   endfunction

   task automatic model_wr(input logic [7:0] a, input logic [31:0] v);
      logic [31:0] w;
      w = v & MASK;
      if (lk) begin
         case (a)
            8'h08: m1 = w;
            8'h0C: m0 = w;
            8'h50: m1 = m1 & ~w;
            8'h54: m0 = m0 | w;
            8'h58: m0 = m0 & ~w;
            default: ;
         endcase
      end
      if (a == 8'h14) dd = dd | w;
      if (a == 8'h18) dd = dd & ~w;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] v);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
      @(negedge clk);
      reg_wr_en = 1'b0;
      model_wr(a, v);
   endtask

   task automatic lkwr(input logic [31:0] v);
      @(negedge clk);
      lk_wr_en = 1'b1; lk_wdata = v;
      @(negedge clk);
      lk_wr_en = 1'b0;
      if (v[15:0] == 16'hD42F) lk = 1;
      else if (v[15:0] == 16'h0000) lk = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic check_all(input string tag);
      logic [31:0] v;
      rd(8'h08, v); chk(v == m1, {tag, " mode1 R4"}, v, m1);
      rd(8'h0C, v); chk(v == m0, {tag, " mode0 R4"}, v, m0);
      chk(lk_rdata == {lk, 31'b0}, {tag, " lock R2"}, lk_rdata, {lk, 31'b0});
      chk(32'(pad_oe) == exp_oe(m1, m0, dd), {tag, " oe R7-R10"},
          32'(pad_oe), exp_oe(m1, m0, dd));
      chk(32'(pad_out) == exp_out(m1, m0, dd), {tag, " out R8/R9/R10"},
          32'(pad_out), exp_out(m1, m0, dd));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired R1 actual=%h expected=%h", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [7:0] addrs [8];
      addrs = '{8'h04, 8'h08, 8'h0C, 8'h14, 8'h18, 8'h50, 8'h54, 8'h58};
      v = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(8'h08, v); chk(v == 0, "R1 mode1", v, 0);
      rd(8'h0C, v); chk(v == 0, "R1 mode0", v, 0);
      chk(32'(pad_oe) == 0, "R1 oe", 32'(pad_oe), 0);
      chk(lk_rdata == 0, "R1 lock", lk_rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: writes ignored while unlocked
      wr(8'h0C, 32'hFFFF_FFFF);
      wr(8'h08, 32'h0000_00FF);
      wr(8'h54, 32'h0000_0F0F);
      check_all("R3 unlocked");

      // R2: non-key value leaves lock closed, key opens it
      lkwr(32'h1234_5678);
      chk(lk_rdata == 0, "R2 junk keeps closed", lk_rdata, 0);
      lkwr(32'hFFFF_D42F);
      chk(lk_rdata == 32'h8000_0000, "R2 key opens", lk_rdata, 32'h8000_0000);
      lkwr(32'h0000_0001);
      chk(lk_rdata == 32'h8000_0000, "R2 junk keeps open", lk_rdata, 32'h8000_0000);

      // R12: upper bits ignored
      wr(8'h0C, 32'hFFFF_FFFF);
      rd(8'h0C, v); chk(v == MASK, "R12 mode0 width", v, MASK);
      // R4 / R5 directed: all four modes across pins
      wr(8'h08, 32'h0000_0F0F);
      wr(8'h58, 32'h0000_3333);
      wr(8'h14, 32'h0005_5555);
      check_all("R5 R7 R8 R9 R10 directed");
      wr(8'h50, 32'h0000_0101);
      wr(8'h54, 32'h0000_0001);
      wr(8'h18, 32'h0000_00F0);
      check_all("R5 R6 directed");

      // R13 reads of other offsets
      rd(8'h14, v); chk(v == 0, "R13 dset reads 0", v, 0);
      rd(8'h54, v); chk(v == 0, "R13 m0set reads 0", v, 0);
      rd(8'h20, v); chk(v == 0, "R13 unmapped", v, 0);

      // R11 synchronizer latency
      @(negedge clk);
      pad_in = 20'hA5C3E;
      reg_addr = 8'h04;
      @(negedge clk);
      rd(8'h04, v); chk(v == 0, "R11 one edge still old", v, 0);
      @(negedge clk);
      rd(8'h04, v); chk(v == 32'h000A_5C3E, "R11 two edges", v, 32'h000A_5C3E);

      // R2 release
      lkwr(32'hABCD_0000);
      chk(lk_rdata == 0, "R2 release", lk_rdata, 0);
      wr(8'h0C, 32'h0);
      check_all("R3 after release");

      // random phase
      for (int it = 0; it < 400; it++) begin
         int sel;
         sel = $urandom_range(0, 9);
         if (sel == 0) lkwr(32'h0000_D42F | ($urandom & 32'hFFFF_0000));
         else if (sel == 1) lkwr($urandom & 32'hFFFF_0000);
         else if (sel == 2) lkwr($urandom);
         else if (sel == 3) begin
            logic [31:0] p;
            p = $urandom;
            @(negedge clk);
            pad_in = p[NP-1:0];
            @(negedge clk);
            @(negedge clk);
            rd(8'h04, v);
            chk(v == (p & MASK), "R11 random", v, p & MASK);
         end else wr(addrs[$urandom_range(1, 7)], $urandom);
         check_all("random R3 R4 R5 R6");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule